// File: doc/BRIEF.md
# Packed Colour Palette RAM

This block holds a 256-colour lookup table for a display pipeline. Software loads it over a simple register bus through an address window of 128 word slots. Each 32-bit word carries two 16-bit colour entries. A bus read of a slot returns the word exactly as it was last written, including bits that the colour path never uses.

A separate lookup port serves the pixel pipeline. It takes an 8-bit colour index and, one cycle later, returns a 24-bit colour. The 24-bit value is built by widening the three 5-bit channel fields of the selected entry to 8 bits. A channel-order input can exchange the red and blue outputs. When a bus write and a lookup hit the same word in one cycle, the lookup sees the new data.

Top module: `clut_pack_ram`

## Requirements
- R1: While reset is held and after it is released, `busRdValid`, `rgbValid`, `busRdData` and `rgbOut` are zero. Every palette word reads back as zero, and every index looks up as zero, until software writes it.
- R2: A bus read at byte address 0x200 + 4n, with n from 0 to 127, returns on the next cycle the raw 32-bit value last written to that address, with `busRdValid` high for that one cycle.
- R3: A write outside 0x200..0x3FC, or to an address whose two low bits are not zero, changes no palette word. A read at such an address returns zero, with `busRdValid` still high on the next cycle.
- R4: Index 2n selects bits 15:0 of word n, and index 2n+1 selects bits 31:16 of word n.
- R5: Within an entry, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue. Each channel appears as the 5-bit value shifted left by three, with the three low bits zero. The output is laid out as red in 23:16, green in 15:8 and blue in 7:0.
- R6: Bit 15 of an entry has no effect on the looked-up colour.
- R7: When `bgrSwap` is high in the lookup cycle, the red and blue output channels are exchanged and green stays in place.
- R8: `rgbValid` is high exactly in the cycle after `lkValid` was high, and `rgbOut` holds the result of that lookup.
- R9: When a write to word n and a lookup of index 2n or 2n+1 occur in the same cycle, the lookup returns the colour from the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address on the register bus |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid one cycle after the strobe |
| busRdValid | output | 1 | Read data valid |
| lkValid | input | 1 | Lookup request |
| lkIndex | input | 8 | Colour index to look up |
| bgrSwap | input | 1 | Exchange red and blue on this lookup |
| rgbOut | output | 24 | Expanded colour {R,G,B} |
| rgbValid | output | 1 | Lookup result valid |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a window base of 0x200, 128 words and 5-bit channels widened to 8 bits. With these values the bench can reach both edges of the window (0x200 and 0x3FC), the addresses just outside it (0x1FC and 0x400), a misaligned address inside it, and both the lowest and highest indices (0 and 255). Entries with the intensity bit set and cleared are looked up in both channel orders. Writes and lookups to the same word are placed in the same cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Strobes passed from the address decoder to the storage datapath.
  typedef struct packed {
    logic wrStb;   // in-window aligned write
    logic rdStb;   // any bus read
    logic rdHit;   // bus read that lands in the window
    logic lkStb;   // colour lookup request
  } clut_strb_t;

  localparam int NUM_CHAN = 3;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic                       lkValid,
  output clut_pkg::clut_strb_t       strb,
  output logic [$clog2(WORDS)-1:0]   wordIdx
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [ADDR_W-1:0] offs;
  logic              inWindow;

  assign offs     = busAddr - BASE_A;
  assign inWindow = (busAddr >= BASE_A)
                 && (offs[ADDR_W-1:IDX_W+2] == '0)
                 && (offs[1:0] == 2'b00);
  assign wordIdx  = offs[IDX_W+1:2];

  always_comb begin
    strb       = '0;
    strb.wrStb = busWrEn && inWindow;
    strb.rdStb = busRdEn;
    strb.rdHit = busRdEn && inWindow;
    strb.lkStb = lkValid;
  end

  // R3
  wr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStb |-> (busWrEn && busAddr >= BASE_A && busAddr[1:0] == 2'b00));

  // R3
  rd_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdHit |-> strb.rdStb);

endmodule

// File: rtl/clut_dpath.sv
module clut_dpath #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int OUT_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  clut_pkg::clut_strb_t          strb,
  input  logic [$clog2(WORDS)-1:0]      wordIdx,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [$clog2(WORDS):0]        lkIndex,
  input  logic                          bgrSwap,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic [3*OUT_W-1:0]            rgbOut,
  output logic                          rgbValid
);

  localparam int IDX_W   = $clog2(WORDS);
  localparam int ENTRY_W = DATA_W / 2;
  localparam int COL_W   = clut_pkg::NUM_CHAN * CH_W;
  localparam int PAD_W   = OUT_W - CH_W;

  logic [DATA_W-1:0] mem [WORDS];

  logic [IDX_W-1:0]  lkWordIdx;
  logic              bypass;
  logic [COL_W-1:0]  colour;
  logic [OUT_W-1:0]  expd [clut_pkg::NUM_CHAN];
  logic [3*OUT_W-1:0] rgbNext;

  // Storage and bus read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.wrStb) mem[wordIdx] <= wrData;
      rdValid <= strb.rdStb;
      rdData  <= strb.rdHit ? mem[wordIdx] : '0;
    end
  end

  // Entry selection with same-cycle write forwarding
  assign lkWordIdx = lkIndex[IDX_W:1];
  assign bypass    = strb.wrStb && (wordIdx == lkWordIdx);

  always_comb begin
    if (lkIndex[0])
      colour = bypass ? wrData[ENTRY_W +: COL_W] : mem[lkWordIdx][ENTRY_W +: COL_W];
    else
      colour = bypass ? wrData[0 +: COL_W]       : mem[lkWordIdx][0 +: COL_W];
  end

  // Channel widening and optional red/blue exchange
  for (genvar c = 0; c < clut_pkg::NUM_CHAN; c++) begin : g_chan
    assign expd[c] = {colour[c*CH_W +: CH_W], {PAD_W{1'b0}}};
    assign rgbNext[OUT_W*(clut_pkg::NUM_CHAN-1-c) +: OUT_W] =
      bgrSwap ? expd[clut_pkg::NUM_CHAN-1-c] : expd[c];

    // R5
    low_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
      rgbValid |-> (rgbOut[OUT_W*c +: PAD_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rgbOut   <= '0;
      rgbValid <= 1'b0;
    end else begin
      rgbValid <= strb.lkStb;
      if (strb.lkStb) rgbOut <= rgbNext;
    end
  end

  // R8
  lk_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lkStb |=> rgbValid);

  // R8
  lk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lkStb |=> !rgbValid);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStb |=> rdValid);

  // R3
  rd_miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStb && !strb.rdHit) |=> (rdData == '0));

  // R8
  rgb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lkStb |=> $stable(rgbOut));

endmodule

// File: rtl/clut_pack_ram.sv
module clut_pack_ram #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [DATA_W-1:0]        busWrData,
  input  logic                     busRdEn,
  output logic [DATA_W-1:0]        busRdData,
  output logic                     busRdValid,
  input  logic                     lkValid,
  input  logic [$clog2(WORDS):0]   lkIndex,
  input  logic                     bgrSwap,
  output logic [3*OUT_W-1:0]       rgbOut,
  output logic                     rgbValid
);

  clut_pkg::clut_strb_t       strb;
  logic [$clog2(WORDS)-1:0]   wordIdx;

  clut_ctrl #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .WORDS  (WORDS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .lkValid (lkValid),
    .strb    (strb),
    .wordIdx (wordIdx)
  );

  clut_dpath #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .OUT_W  (OUT_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .wrData   (busWrData),
    .lkIndex  (lkIndex),
    .bgrSwap  (bgrSwap),
    .rdData   (busRdData),
    .rdValid  (busRdValid),
    .rgbOut   (rgbOut),
    .rgbValid (rgbValid)
  );

endmodule

// File: tb/test_clut_pack_ram.sv
module test_clut_pack_ram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busRdValid;
  logic        lkValid = 1'b0;
  logic [7:0]  lkIndex = '0;
  logic        bgrSwap = 1'b0;
  logic [23:0] rgbOut;
  logic        rgbValid;

  clut_pack_ram i_clut_pack_ram (
    .clk (clk), .rstN (rstN),
    .busAddr (busAddr), .busWrEn (busWrEn), .busWrData (busWrData),
    .busRdEn (busRdEn), .busRdData (busRdData), .busRdValid (busRdValid),
    .lkValid (lkValid), .lkIndex (lkIndex), .bgrSwap (bgrSwap),
    .rgbOut (rgbOut), .rgbValid (rgbValid)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [31:0] data;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        rdQ[$];
  exp_t        lkQ[$];
  logic [31:0] model [128];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          monOn = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expand(logic [15:0] e, bit swap);
    logic [7:0] r, g, b;
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    return swap ? {b, g, r} : {r, g, b};
  endfunction

  function automatic logic [23:0] lookupExp(logic [7:0] idx, bit swap);
    logic [31:0] w;
    w = model[idx[7:1]];
    return expand(idx[0] ? w[31:16] : w[15:0], swap);
  endfunction

  function automatic bit inWin(logic [11:0] a);
    return (a >= 12'h200) && (a <= 12'h3FC) && (a[1:0] == 2'b00);
  endfunction

  task automatic setIdle();
    busWrEn = 1'b0; busRdEn = 1'b0; lkValid = 1'b0; bgrSwap = 1'b0;
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    setIdle();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    if (inWin(a)) model[(a - 12'h200) >> 2] = d;
  endtask

  task automatic busRead(logic [11:0] a, string tag);
    exp_t e;
    @(negedge clk);
    setIdle();
    busAddr = a; busRdEn = 1'b1;
    e.data = inWin(a) ? model[(a - 12'h200) >> 2] : 32'h0;
    e.cyc = cyc + 1; e.tag = tag;
    rdQ.push_back(e);
  endtask

  task automatic lookup(logic [7:0] idx, bit swap, string tag);
    exp_t e;
    @(negedge clk);
    setIdle();
    lkIndex = idx; bgrSwap = swap; lkValid = 1'b1;
    e.data = {8'h0, lookupExp(idx, swap)};
    e.cyc = cyc + 1; e.tag = tag;
    lkQ.push_back(e);
  endtask

  // Write and lookup in one cycle (R9)
  task automatic writeLook(logic [11:0] a, logic [31:0] d, logic [7:0] idx, bit swap);
    exp_t e;
    @(negedge clk);
    setIdle();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    lkIndex = idx; bgrSwap = swap; lkValid = 1'b1;
    if (inWin(a)) model[(a - 12'h200) >> 2] = d;
    e.data = {8'h0, lookupExp(idx, swap)};
    e.cyc = cyc + 1; e.tag = "R9 write-forward lookup";
    lkQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      setIdle();
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (monOn) begin
      if (busRdValid) begin
        if (rdQ.size() == 0) check("R2 unexpected read valid", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = rdQ.pop_front();
          check(e.tag, busRdData, e.data);
          check({e.tag, " latency"}, 32'(cyc), 32'(e.cyc));
        end
      end
      if (rgbValid) begin
        if (lkQ.size() == 0) check("R8 unexpected rgb valid", 32'h1, 32'h0);
        else begin
          exp_t e;
          e = lkQ.pop_front();
          check(e.tag, {8'h0, rgbOut}, e.data);
          check({e.tag, " R8 latency"}, 32'(cyc), 32'(e.cyc));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1 rdValid in reset", {31'h0, busRdValid}, 32'h0);
    check("R1 rgbValid in reset", {31'h0, rgbValid}, 32'h0);
    check("R1 rdData in reset", busRdData, 32'h0);
    check("R1 rgbOut in reset", {8'h0, rgbOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rgbOut after reset", {8'h0, rgbOut}, 32'h0);
    monOn = 1'b1;

    busRead(12'h200, "R1 word 0 after reset");
    busRead(12'h3FC, "R1 word 127 after reset");
    lookup(8'd255, 1'b0, "R1 index 255 after reset");

    // R2 raw readback, edges of the window
    busWrite(12'h200, 32'h001F_03E0);
    busWrite(12'h214, 32'h7C00_1234);
    busWrite(12'h3FC, 32'hA5A5_5A5A);
    busWrite(12'h204, 32'h8000_0000);
    busWrite(12'h208, 32'hFFFF_FFFF);
    busWrite(12'h20C, 32'h7FFF_7FFF);
    busRead(12'h200, "R2 word 0 readback");
    busRead(12'h214, "R2 word 5 readback");
    busRead(12'h3FC, "R2 word 127 readback");
    busRead(12'h204, "R2 word 1 readback with high bits");

    // R4 / R5 halfword selection and channel positions
    lookup(8'd0, 1'b0, "R4 R5 index 0 green");
    lookup(8'd1, 1'b0, "R4 R5 index 1 red");
    lookup(8'd10, 1'b0, "R4 R5 index 10 mixed");
    lookup(8'd11, 1'b0, "R4 R5 index 11 blue");
    lookup(8'd254, 1'b0, "R4 index 254");
    lookup(8'd255, 1'b0, "R4 index 255");

    // R6 intensity bit ignored
    lookup(8'd3, 1'b0, "R6 intensity only entry");
    lookup(8'd4, 1'b0, "R6 full entry with intensity");
    lookup(8'd6, 1'b0, "R6 full entry without intensity");

    // R7 red/blue exchange
    lookup(8'd1, 1'b1, "R7 red moves to blue");
    lookup(8'd11, 1'b1, "R7 blue moves to red");
    lookup(8'd10, 1'b1, "R7 mixed swapped");
    idle(3);

    // R3 writes outside window or misaligned are dropped
    busWrite(12'h1FC, 32'hDEAD_BEEF);
    busWrite(12'h400, 32'hCAFE_F00D);
    busWrite(12'h202, 32'h1234_5678);
    busWrite(12'hFFC, 32'h0BAD_0BAD);
    busRead(12'h200, "R3 word 0 untouched");
    busRead(12'h3FC, "R3 word 127 untouched");
    busRead(12'h400, "R3 read above window");
    busRead(12'h1FC, "R3 read below window");
    busRead(12'h202, "R3 misaligned read");
    lookup(8'd0, 1'b0, "R3 index 0 untouched");

    // R9 same-cycle write and lookup of the same word
    writeLook(12'h280, 32'h03E0_7C00, 8'd64, 1'b0);
    writeLook(12'h280, 32'h001F_0000, 8'd65, 1'b0);
    writeLook(12'h284, 32'h4210_0421, 8'd66, 1'b1);
    lookup(8'd64, 1'b0, "R9 stored after forward");
    // back-to-back lookups (R8)
    lookup(8'd65, 1'b0, "R8 back-to-back a");
    lookup(8'd67, 1'b0, "R8 back-to-back b");
    idle(4);

    check("R8 lookup queue drained", 32'(lkQ.size()), 32'h0);
    check("R2 read queue drained", 32'(rdQ.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule